// File: doc/BRIEF.md
# Execute-Stage Bypass and Load-Use Stall Control

This block decides, for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback), where each execute-stage operand comes from. It also decides when the front of the pipe must pause. For each of the two source indices of the instruction now in execute, it compares the index with the destination of the instruction one step ahead (held in the EX/MEM register) and the one two steps ahead (held in MEM/WB). It then emits a select code for the operand multiplexer in front of the ALU.

A separate check looks at the instruction sitting in ID/EX. If that instruction is a load whose destination is read by the instruction now in decode, the block asks the PC and IF/ID registers to hold and asks ID/EX to take a bubble. After one cycle the bubble has replaced the load in ID/EX, so the request drops by itself. The consumer then picks up the loaded value over the MEM/WB path. The multiplexers, the register file and the ALU are outside the block. The logic is purely combinational.

Top module: `opnd_bypass_hazard`

## Requirements
- R1: With no producer whose write enable is set, both select outputs are 2'b00 (register-file value), and both `stall_front` and `bubble_idex` are 0.
- R2: When the EX/MEM producer has its write enable set and a destination equal to a nonzero execute-stage source, that operand's select is 2'b10.
- R3: When only the MEM/WB producer has its write enable set and a destination matching a nonzero execute-stage source, that operand's select is 2'b01.
- R4: When both producers match the same source, the select is 2'b10, because the EX/MEM value is the newer one.
- R5: Source index 0 never selects a bypass and never causes a stall. A producer whose write enable is 0 never matches.
- R6: When ID/EX holds a load with its write enable set and a nonzero destination equal to either decode-stage source, `stall_front` and `bubble_idex` are both 1.
- R7: A non-load producer in ID/EX never causes a stall. Back-to-back dependent ALU instructions are served only by the 2'b10 path.
- R8: `stall_front` and `bubble_idex` are always equal. Once the bubble has cleared the ID/EX write enable and load flag, the request is 0, so a load-use pause lasts exactly one cycle.
- R9: The two operand selects are decided independently, so they may carry different codes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | IDX_W | First source index of the instruction in decode |
| id_rs2 | input | IDX_W | Second source index of the instruction in decode |
| ex_rs1 | input | IDX_W | First source index of the instruction in execute |
| ex_rs2 | input | IDX_W | Second source index of the instruction in execute |
| idex_rd | input | IDX_W | Destination index held in ID/EX |
| idex_wr_en | input | 1 | Register-write enable held in ID/EX |
| idex_is_load | input | 1 | Load flag held in ID/EX |
| exmem_rd | input | IDX_W | Destination index held in EX/MEM |
| exmem_wr_en | input | 1 | Register-write enable held in EX/MEM |
| memwb_rd | input | IDX_W | Destination index held in MEM/WB |
| memwb_wr_en | input | 1 | Register-write enable held in MEM/WB |
| fwd_sel_a | output | 2 | Operand A mux select: 00 register file, 10 EX/MEM, 01 MEM/WB |
| fwd_sel_b | output | 2 | Operand B mux select, same encoding |
| stall_front | output | 1 | Hold request for PC and IF/ID |
| bubble_idex | output | 1 | Request to clear ID/EX control into a no-op |

## Verification
The bench builds the block with the default five-bit register index. This reaches register 31 at the top of the index range as well as register 0, so it covers the all-ones compare and the zero-index exclusion. The directed sequences replay a load followed by three dependent instructions cycle by cycle: the stall, the bubble, the MEM/WB pickup and the EX/MEM pickup in order. They also cover priority when both paths match and operands with different selects in the same cycle.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        SEL_RF    = 2'b00,
        SEL_MEMWB = 2'b01,
        SEL_EXMEM = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        fwd_sel_e sel_a;
        fwd_sel_e sel_b;
        logic     hold;
    } ctl_t;

endpackage

// File: rtl/bypass_pick.sv
module bypass_pick
    import fwd_pkg::*;
#(
    parameter int unsigned IDX_W = 5
) (
    input  logic [IDX_W-1:0] src_idx,
    input  logic             near_wr,
    input  logic [IDX_W-1:0] near_rd,
    input  logic             far_wr,
    input  logic [IDX_W-1:0] far_rd,
    output fwd_sel_e         sel
);
    localparam logic [IDX_W-1:0] ZERO_IDX = '0;

    logic near_hit_d;
    logic far_hit_d;

    always_comb begin
        near_hit_d = near_wr && (near_rd == src_idx) && (src_idx != ZERO_IDX);
        far_hit_d  = far_wr  && (far_rd  == src_idx) && (src_idx != ZERO_IDX);
        if (near_hit_d)
            sel = SEL_EXMEM;
        else if (far_hit_d)
            sel = SEL_MEMWB;
        else
            sel = SEL_RF;
    end

    always_comb begin
        // R5: the zero register is never bypassed
        a_r5_zero_src_rf: assert (src_idx != ZERO_IDX || sel == SEL_RF)
            else $error("zero source picked a bypass");
        // R3: an older-path pick implies a live matching producer there
        a_r3_memwb_pick_valid: assert (sel != SEL_MEMWB || (far_wr && far_rd == src_idx))
            else $error("MEM/WB pick without matching producer");
        // R4: a newer-path match must never be overridden by the older path
        a_r4_exmem_priority: assert (!(near_wr && near_rd == src_idx && src_idx != ZERO_IDX) || sel == SEL_EXMEM)
            else $error("EX/MEM match lost priority");
    end

endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
    parameter int unsigned IDX_W   = 5,
    parameter int unsigned NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0][IDX_W-1:0] dec_src,
    input  logic                          prod_wr,
    input  logic                          prod_load,
    input  logic [IDX_W-1:0]              prod_rd,
    output logic                          hazard
);
    localparam logic [IDX_W-1:0] ZERO_IDX = '0;

    logic [NUM_SRC-1:0] hit_d;

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            hit_d[i] = (dec_src[i] == prod_rd) && (dec_src[i] != ZERO_IDX);
        end
        hazard = prod_wr && prod_load && (|hit_d);
    end

    always_comb begin
        // R7: only a load in ID/EX may pause the front end
        a_r7_load_only_stall: assert (!hazard || prod_load)
            else $error("stall without load producer");
        // R8: a cleared (bubbled) ID/EX stage never requests a stall
        a_r8_bubble_releases: assert (prod_wr || !hazard)
            else $error("stall with write enable cleared");
    end

endmodule

// File: rtl/opnd_bypass_hazard.sv
module opnd_bypass_hazard
    import fwd_pkg::*;
#(
    parameter int unsigned IDX_W = 5
) (
    input  logic [IDX_W-1:0] id_rs1,
    input  logic [IDX_W-1:0] id_rs2,
    input  logic [IDX_W-1:0] ex_rs1,
    input  logic [IDX_W-1:0] ex_rs2,
    input  logic [IDX_W-1:0] idex_rd,
    input  logic             idex_wr_en,
    input  logic             idex_is_load,
    input  logic [IDX_W-1:0] exmem_rd,
    input  logic             exmem_wr_en,
    input  logic [IDX_W-1:0] memwb_rd,
    input  logic             memwb_wr_en,
    output logic [1:0]       fwd_sel_a,
    output logic [1:0]       fwd_sel_b,
    output logic             stall_front,
    output logic             bubble_idex
);
    localparam int unsigned NUM_SRC = 2;

    logic [NUM_SRC-1:0][IDX_W-1:0] ex_src;
    logic [NUM_SRC-1:0][IDX_W-1:0] id_src;
    fwd_sel_e                      pick_w [NUM_SRC];
    logic                          hazard_w;
    ctl_t                          ctl_d;

    assign ex_src[0] = ex_rs1;
    assign ex_src[1] = ex_rs2;
    assign id_src[0] = id_rs1;
    assign id_src[1] = id_rs2;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_pick
        bypass_pick #(.IDX_W(IDX_W)) pick_i (
            .src_idx (ex_src[g]),
            .near_wr (exmem_wr_en),
            .near_rd (exmem_rd),
            .far_wr  (memwb_wr_en),
            .far_rd  (memwb_rd),
            .sel     (pick_w[g])
        );
    end

    load_use_detect #(.IDX_W(IDX_W), .NUM_SRC(NUM_SRC)) luse_i (
        .dec_src   (id_src),
        .prod_wr   (idex_wr_en),
        .prod_load (idex_is_load),
        .prod_rd   (idex_rd),
        .hazard    (hazard_w)
    );

    always_comb begin
        ctl_d.sel_a = pick_w[0];
        ctl_d.sel_b = pick_w[1];
        ctl_d.hold  = hazard_w;
    end

    assign fwd_sel_a   = ctl_d.sel_a;
    assign fwd_sel_b   = ctl_d.sel_b;
    assign stall_front = ctl_d.hold;
    assign bubble_idex = ctl_d.hold;

    always_comb begin
        // R2: the unused code 2'b11 never reaches the muxes
        a_r2_sel_legal: assert (fwd_sel_a != 2'b11 && fwd_sel_b != 2'b11)
            else $error("illegal select code");
        // R1: with no live producers nothing is bypassed or stalled
        a_r1_idle_quiet: assert (exmem_wr_en || memwb_wr_en || idex_wr_en ||
                                 (fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00 && !stall_front))
            else $error("activity with no producers");
    end

endmodule

// File: tb/opnd_bypass_hazard_tb_top.sv
module opnd_bypass_hazard_tb_top;

    localparam int unsigned IDX_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [IDX_W-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, idex_rd, exmem_rd, memwb_rd;
    logic idex_wr_en, idex_is_load, exmem_wr_en, memwb_wr_en;
    logic [1:0] fwd_sel_a, fwd_sel_b;
    logic stall_front, bubble_idex;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    opnd_bypass_hazard #(.IDX_W(IDX_W)) dut_i (
        .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
        .idex_rd(idex_rd), .idex_wr_en(idex_wr_en), .idex_is_load(idex_is_load),
        .exmem_rd(exmem_rd), .exmem_wr_en(exmem_wr_en),
        .memwb_rd(memwb_rd), .memwb_wr_en(memwb_wr_en),
        .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
        .stall_front(stall_front), .bubble_idex(bubble_idex)
    );

    task automatic drive(input int d1, input int d2, input int e1, input int e2,
                         input int xrd, input bit xwr, input bit xld,
                         input int mrd, input bit mwr, input int wrd, input bit wwr);
        @(negedge clk);
        id_rs1 = d1[IDX_W-1:0]; id_rs2 = d2[IDX_W-1:0];
        ex_rs1 = e1[IDX_W-1:0]; ex_rs2 = e2[IDX_W-1:0];
        idex_rd = xrd[IDX_W-1:0]; idex_wr_en = xwr; idex_is_load = xld;
        exmem_rd = mrd[IDX_W-1:0]; exmem_wr_en = mwr;
        memwb_rd = wrd[IDX_W-1:0]; memwb_wr_en = wwr;
        #1;
    endtask

    task automatic expect_out(input string req, input logic [1:0] ea, input logic [1:0] eb,
                              input logic es);
        checks++;
        if (fwd_sel_a !== ea || fwd_sel_b !== eb || stall_front !== es || bubble_idex !== es) begin
            errors++;
            $display("FAIL %s: got a=%b b=%b stall=%b bubble=%b, expected a=%b b=%b stall=%b bubble=%b",
                     req, fwd_sel_a, fwd_sel_b, stall_front, bubble_idex, ea, eb, es, es);
        end
    endtask

    task automatic t_idle();
        drive(3, 4, 3, 4, 3, 0, 1, 3, 0, 4, 0);
        expect_out("R1 idle", 2'b00, 2'b00, 1'b0);
    endtask

    task automatic t_exmem();
        drive(0, 0, 7, 2, 0, 0, 0, 7, 1, 0, 0);
        expect_out("R2 exmem on A", 2'b10, 2'b00, 1'b0);
        drive(0, 0, 2, 31, 0, 0, 0, 31, 1, 0, 0);
        expect_out("R2 exmem on B reg31", 2'b00, 2'b10, 1'b0);
    endtask

    task automatic t_memwb();
        drive(0, 0, 9, 9, 0, 0, 0, 5, 1, 9, 1);
        expect_out("R3 memwb both", 2'b01, 2'b01, 1'b0);
    endtask

    task automatic t_both();
        drive(0, 0, 6, 6, 0, 0, 0, 6, 1, 6, 1);
        expect_out("R4 exmem priority", 2'b10, 2'b10, 1'b0);
    endtask

    task automatic t_zero_disabled();
        drive(0, 0, 0, 0, 0, 1, 1, 0, 1, 0, 1);
        expect_out("R5 zero register", 2'b00, 2'b00, 1'b0);
        drive(0, 0, 8, 8, 0, 0, 0, 8, 0, 8, 0);
        expect_out("R5 write enable low", 2'b00, 2'b00, 1'b0);
        drive(0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0);
        expect_out("R5 zero load no stall", 2'b00, 2'b00, 1'b0);
    endtask

    task automatic t_load_use();
        drive(12, 4, 0, 0, 12, 1, 1, 0, 0, 0, 0);
        expect_out("R6 load-use rs1", 2'b00, 2'b00, 1'b1);
        drive(4, 12, 0, 0, 12, 1, 1, 0, 0, 0, 0);
        expect_out("R6 load-use rs2", 2'b00, 2'b00, 1'b1);
        drive(4, 13, 0, 0, 12, 1, 1, 0, 0, 0, 0);
        expect_out("R6 load no match", 2'b00, 2'b00, 1'b0);
    endtask

    task automatic t_alu_chain();
        drive(10, 11, 0, 0, 10, 1, 0, 0, 0, 0, 0);
        expect_out("R7 alu producer no stall", 2'b00, 2'b00, 1'b0);
        drive(0, 0, 10, 11, 0, 0, 0, 10, 1, 0, 0);
        expect_out("R7 alu chain via exmem", 2'b10, 2'b00, 1'b0);
    endtask

    // Load x1 / add x3,x1,x4 / sub x5,x3,x6 / and x7,x1,x8 replayed cycle by cycle
    task automatic t_lw_sequence();
        drive(1, 4, 2, 0, 1, 1, 1, 0, 0, 0, 0);
        expect_out("R8 seq stall cycle", 2'b00, 2'b00, 1'b1);
        drive(1, 4, 0, 0, 0, 0, 0, 1, 1, 0, 0);
        expect_out("R8 seq bubble releases", 2'b00, 2'b00, 1'b0);
        drive(3, 6, 1, 4, 3, 1, 0, 0, 0, 1, 1);
        expect_out("R8 seq add via memwb", 2'b01, 2'b00, 1'b0);
        drive(1, 8, 3, 6, 5, 1, 0, 3, 1, 0, 0);
        expect_out("R8 seq sub via exmem", 2'b10, 2'b00, 1'b0);
        drive(0, 0, 1, 8, 7, 1, 0, 5, 1, 3, 1);
        expect_out("R8 seq and from regfile", 2'b00, 2'b00, 1'b0);
    endtask

    task automatic t_independent();
        drive(0, 0, 14, 15, 0, 0, 0, 14, 1, 15, 1);
        expect_out("R9 independent selects", 2'b10, 2'b01, 1'b0);
        drive(0, 0, 15, 14, 0, 0, 0, 14, 1, 15, 1);
        expect_out("R9 swapped selects", 2'b01, 2'b10, 1'b0);
    endtask

    initial begin
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        expect_out("R1 reset state", 2'b00, 2'b00, 1'b0);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_exmem();
        t_memwb();
        t_both();
        t_zero_disabled();
        t_load_use();
        t_alu_chain();
        t_lw_sequence();
        t_independent();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule